// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Protector

This block guards 32-bit memory words with seven check bits. On the write side it forms the check bits from the outgoing word so that they can be stored next to it. On the read side it forms them again from the returned word and XORs them with the stored bits to make a syndrome.

Any single flipped data bit is located and repaired in the returned word. A single flipped check bit is flagged while the data passes unchanged. Every other nonzero syndrome is reported as uncorrectable. A write that arrives with a bus parity error gets deliberately spoiled check bits, so that the word reads back later as a known uncorrectable pattern.

Each event is recorded in a 32-bit status word. Software reads it and clears its flag bits by writing ones. The block is purely combinational from data in to data out, and the status word updates on the clock edge that follows the read. Memory timing belongs to the surrounding controller.

Top module: `ecc_guard`

## Requirements
- R1: Check bit j (wrCheck[j], j=0..6) is the XOR of the write word ANDed with a fixed group mask, then XORed with bit j of the constant 7'b0111100. The masks for j=0..6 are F0F0F0F0, 3C3C3C3C, 5A5A5A5A, FF00FFFF, FFFF00FF, FFFFFF00 and 96696969 (hex).
- R2: The zero word encodes to 7'b0111100. Toggling data bit 28 inverts all seven check bits. Complementing the whole word leaves the check bits unchanged.
- R3: The syndrome is rdCheck XOR the code of rdData. A zero syndrome raises no flag, and corrData equals rdData.
- R4: A syndrome equal to the code column of data bit k (the code of the word with only bit k set, XORed with 7'b0111100) inverts bit k of corrData and raises corrErr when rdValid is high. Examples: bit 0 is 1011000, bit 28 is 1111111, bit 31 is 1111001.
- R5: A syndrome with exactly one bit set raises chkErr, and corrData equals rdData.
- R6: Any other nonzero syndrome, including any two flipped data bits, raises uncorrErr, and corrData equals rdData. At most one of the three flags is high at any time.
- R7: While wrParErr is high, wrCheck is the R1 code XORed with 7'b0000111. A cycle with wrEn and wrParErr both high sets status bit 7. Reading the poisoned word back gives syndrome 0000111, which is uncorrectable.
- R8: Status layout: bit 31 uncorrectable, bit 30 repeated uncorrectable, bit 29 correctable, bits 28:9 page, bit 8 DMA, bit 7 bus parity, bits 6:0 syndrome. An uncorrectable read while bit 31 is clear sets bit 31 and captures rdPage and the syndrome. The status word is zero after reset.
- R9: An uncorrectable read while bit 31 is set sets bit 30 and leaves the page and syndrome fields unchanged.
- R10: A correctable read (data bit or check bit) sets bit 29. It updates the page and syndrome fields only while bit 31 is clear.
- R11: A status write clears bits 31, 30, 29, 8 and 7 wherever its data holds a one. Bits 28:9 and 6:0 ignore writes.
- R12: Any logged error read with rdDma high sets bit 8.
- R13: While rdValid is low, the flags stay low and the status word does not change, whatever the read inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write access in progress |
| wrData | input | 32 | Word being written |
| wrParErr | input | 1 | Bus parity error seen on the write |
| wrCheck | output | 7 | Check bits to store |
| rdValid | input | 1 | Read word present on rdData and rdCheck |
| rdData | input | 32 | Word read from memory |
| rdCheck | input | 7 | Check bits read from memory |
| rdPage | input | 20 | 512-byte page number of the access |
| rdDma | input | 1 | Read issued on behalf of DMA |
| corrData | output | 32 | Read word after correction |
| corrErr | output | 1 | Single data-bit error repaired |
| chkErr | output | 1 | Single check-bit error |
| uncorrErr | output | 1 | Uncorrectable error |
| csrWrEn | input | 1 | Status write strobe |
| csrWrData | input | 32 | Status write data (ones clear flags) |
| csrRdData | output | 32 | Status word |

## Verification
The hardest case to reach from the ports is a stack of errors in which an uncorrectable error is already logged. In that state later errors must raise only flag bits and must leave the captured page and syndrome alone. The bench builds it with a fixed sequence: a correctable read on one page, an uncorrectable read on a second page, a further uncorrectable read and then a correctable read on other pages. It checks the whole status word after each step. To reach every syndrome class, the bench sweeps all 32 single data-bit flips, all 7 check-bit flips and all 496 data-bit pairs against a word of known code.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int PAGE_W = 20;
  localparam int CSR_W  = 32;

  // status field positions
  localparam int B_UNC = CSR_W - 1;
  localparam int B_MUL = CSR_W - 2;
  localparam int B_COR = CSR_W - 3;
  localparam int B_DMA = CHK_W + 1;
  localparam int B_PAR = CHK_W;

  // parity group of each check bit
  localparam logic [DATA_W-1:0] GROUP [CHK_W] = '{
    32'hF0F0F0F0, 32'h3C3C3C3C, 32'h5A5A5A5A, 32'hFF00FFFF,
    32'hFFFF00FF, 32'hFFFFFF00, 32'h96696969};

  localparam logic [CHK_W-1:0] ZERO_CODE = 7'b0111100;
  localparam logic [CHK_W-1:0] POISON    = 7'b0000111;

  typedef struct packed {
    logic doCorrect;
    logic setUnc;
    logic setMul;
    logic setCor;
    logic capture;
    logic setDma;
    logic setPar;
  } strobe_t;

  function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    for (int j = 0; j < CHK_W; j++) c[j] = ^(d & GROUP[j]);
    return c ^ ZERO_CODE;
  endfunction
endpackage

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrParErr,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  logic [PAGE_W-1:0] rdPage,
  input  strobe_t           stb,
  output logic [CHK_W-1:0]  syndrome,
  output logic [DATA_W-1:0] flipMask,
  output logic [DATA_W-1:0] corrData,
  input  logic              csrWrEn,
  input  logic [CSR_W-1:0]  csrWrData,
  output logic [CSR_W-1:0]  csrRdData,
  output logic              uncLogged
);
  logic              uncQ, mulQ, corQ, dmaQ, parQ;
  logic [PAGE_W-1:0] pageQ;
  logic [CHK_W-1:0]  synQ;
  logic [CSR_W-1:0]  clrMask;

  assign wrCheck  = encode(wrData) ^ (wrParErr ? POISON : '0);
  assign syndrome = rdCheck ^ encode(rdData);

  // one comparator per data bit against its code column
  for (genvar k = 0; k < DATA_W; k++) begin : g_col
    logic [CHK_W-1:0] col;
    for (genvar j = 0; j < CHK_W; j++) begin : g_bit
      assign col[j] = GROUP[j][k];
    end
    assign flipMask[k] = (syndrome == col);
  end

  assign corrData = stb.doCorrect ? (rdData ^ flipMask) : rdData;
  assign clrMask  = csrWrEn ? csrWrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uncQ  <= 1'b0;
      mulQ  <= 1'b0;
      corQ  <= 1'b0;
      dmaQ  <= 1'b0;
      parQ  <= 1'b0;
      pageQ <= '0;
      synQ  <= '0;
    end else begin
      uncQ <= stb.setUnc | (uncQ & ~clrMask[B_UNC]);
      mulQ <= stb.setMul | (mulQ & ~clrMask[B_MUL]);
      corQ <= stb.setCor | (corQ & ~clrMask[B_COR]);
      dmaQ <= stb.setDma | (dmaQ & ~clrMask[B_DMA]);
      parQ <= stb.setPar | (parQ & ~clrMask[B_PAR]);
      if (stb.capture) begin
        pageQ <= rdPage;
        synQ  <= syndrome;
      end
    end
  end

  assign uncLogged = uncQ;
  assign csrRdData = {uncQ, mulQ, corQ, pageQ, dmaQ, parQ, synQ};

  a_r4_single_flip: assert property (@(posedge clk) disable iff (!rstN)
    stb.doCorrect |-> $countones(corrData ^ rdData) == 1);
  a_r6_data_untouched: assert property (@(posedge clk) disable iff (!rstN)
    !stb.doCorrect |-> corrData == rdData);
  a_r8_fields_held: assert property (@(posedge clk) disable iff (!rstN)
    uncQ |=> ($stable(pageQ) && $stable(synQ)));
  a_r9_repeat_flag: assert property (@(posedge clk) disable iff (!rstN)
    (uncQ && stb.setUnc) |=> mulQ);
  a_r11_clear_cor: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrWrData[B_COR] && !stb.setCor) |=> !corQ);
endmodule

// File: rtl/ecc_control.sv
module ecc_control
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrParErr,
  input  logic              rdValid,
  input  logic              rdDma,
  input  logic [CHK_W-1:0]  syndrome,
  input  logic [DATA_W-1:0] flipMask,
  input  logic              uncLogged,
  output strobe_t           stb,
  output logic              corrErr,
  output logic              chkErr,
  output logic              uncorrErr
);
  logic synNz, dataHit, chkHit, uncHit, anyErr;

  assign synNz   = |syndrome;
  assign dataHit = |flipMask;
  assign chkHit  = $onehot(syndrome);
  assign uncHit  = synNz && !dataHit && !chkHit;

  assign corrErr   = rdValid && dataHit;
  assign chkErr    = rdValid && chkHit;
  assign uncorrErr = rdValid && uncHit;
  assign anyErr    = rdValid && synNz;

  always_comb begin
    stb           = '0;
    stb.doCorrect = dataHit;
    stb.setUnc    = uncorrErr;
    stb.setMul    = uncorrErr && uncLogged;
    stb.setCor    = corrErr || chkErr;
    stb.capture   = anyErr && !uncLogged;
    stb.setDma    = anyErr && rdDma;
    stb.setPar    = wrEn && wrParErr;
  end

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({corrErr, chkErr, uncorrErr}));
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> !(stb.setUnc || stb.setCor || stb.capture || stb.setDma));
  a_r8_capture_once: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMul |-> !stb.capture);
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrParErr,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  logic [PAGE_W-1:0] rdPage,
  input  logic              rdDma,
  output logic [DATA_W-1:0] corrData,
  output logic              corrErr,
  output logic              chkErr,
  output logic              uncorrErr,
  input  logic              csrWrEn,
  input  logic [CSR_W-1:0]  csrWrData,
  output logic [CSR_W-1:0]  csrRdData
);
  strobe_t           stb;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] flipMask;
  logic              uncLogged;

  ecc_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrParErr(wrParErr),
    .rdValid(rdValid), .rdDma(rdDma), .syndrome(syndrome),
    .flipMask(flipMask), .uncLogged(uncLogged), .stb(stb),
    .corrErr(corrErr), .chkErr(chkErr), .uncorrErr(uncorrErr));

  ecc_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrParErr(wrParErr),
    .wrCheck(wrCheck), .rdData(rdData), .rdCheck(rdCheck),
    .rdPage(rdPage), .stb(stb), .syndrome(syndrome),
    .flipMask(flipMask), .corrData(corrData), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .uncLogged(uncLogged));
endmodule

// File: tb/tb_ecc_guard.sv
module tb_ecc_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrParErr = 1'b0, rdValid = 1'b0, rdDma = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [31:0] wrData = '0, rdData = '0, csrWrData = '0;
  logic [6:0]  rdCheck = '0;
  logic [19:0] rdPage = '0;
  logic [6:0]  wrCheck;
  logic [31:0] corrData, csrRdData;
  logic        corrErr, chkErr, uncorrErr;
  int nChecks = 0, nFail = 0;

  localparam logic [31:0] M [7] = '{32'hF0F0F0F0, 32'h3C3C3C3C,
    32'h5A5A5A5A, 32'hFF00FFFF, 32'hFFFF00FF, 32'hFFFFFF00, 32'h96696969};

  ecc_guard dut (.*);

  always #2 clk = ~clk;

  function automatic logic [6:0] mEnc(input logic [31:0] d);
    logic [6:0] c;
    for (int j = 0; j < 7; j++) c[j] = ^(d & M[j]);
    return c ^ 7'b0111100;
  endfunction

  function automatic logic [6:0] mCol(input int k);
    return mEnc(32'h1 << k) ^ mEnc(32'h0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readOnce(input logic [31:0] d, input logic [6:0] c,
                          input logic [19:0] pg, input logic dma);
    @(negedge clk);
    rdValid = 1'b1; rdData = d; rdCheck = c; rdPage = pg; rdDma = dma;
    @(negedge clk);
    rdValid = 1'b0; rdDma = 1'b0;
    #1;
  endtask

  task automatic csrWrite(input logic [31:0] v);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = v;
    @(negedge clk);
    csrWrEn = 1'b0;
    #1;
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] w, lfsr, snap;
    logic [6:0]  c0, syn2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R8 reset status", csrRdData, 32'h0);

    // R2 zero word
    wrData = '0; #1;
    check("R2 zero code", {25'h0, wrCheck}, {25'h0, 7'b0111100});

    // R1 / R2 sweep over pseudo-random words
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wrData = lfsr; #1;
      c0 = wrCheck;
      check("R1 encode", {25'h0, c0}, {25'h0, mEnc(lfsr)});
      wrData = lfsr ^ 32'h1000_0000; #1;
      check("R2 bit28 inverts", {25'h0, wrCheck}, {25'h0, ~c0});
      wrData = ~lfsr; #1;
      check("R2 complement", {25'h0, wrCheck}, {25'h0, c0});
    end

    w = 32'h1357_9BDF;
    @(negedge clk);
    rdValid = 1'b1; rdPage = 20'h0; rdData = w; rdCheck = mEnc(w); #1;
    check("R3 clean data", corrData, w);
    check("R3 clean flags", {29'h0, corrErr, chkErr, uncorrErr}, 32'h0);

    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      rdData = w ^ (32'h1 << k); rdCheck = mEnc(w); #1;
      check("R4 corrected", corrData, w);
      check("R4 flags", {29'h0, corrErr, chkErr, uncorrErr}, 32'h4);
    end
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      rdData = w; rdCheck = mEnc(w) ^ (7'h1 << j); #1;
      check("R5 data kept", corrData, w);
      check("R5 flags", {29'h0, corrErr, chkErr, uncorrErr}, 32'h2);
    end
    for (int a = 0; a < 32; a++) begin
      for (int b = a + 1; b < 32; b++) begin
        @(negedge clk);
        rdData = w ^ (32'h1 << a) ^ (32'h1 << b); rdCheck = mEnc(w); #1;
        check("R6 double", {corrData[31:1], uncorrErr},
              {rdData[31:1] , 1'b1} | {31'h0, corrErr | chkErr});
      end
    end
    @(negedge clk);
    rdValid = 1'b0;
    #1;

    // R11 clear all flags; read-only fields stay
    snap = csrRdData;
    csrWrite(32'hFFFF_FFFF);
    check("R11 clear flags", csrRdData, snap & 32'h1FFF_FE7F);

    // R13 ignored read
    snap = csrRdData;
    @(negedge clk);
    rdValid = 1'b0; rdData = w ^ 32'h3; rdCheck = mEnc(w); rdPage = 20'hFFFFF; rdDma = 1'b1; #1;
    check("R13 flags low", {29'h0, corrErr, chkErr, uncorrErr}, 32'h0);
    @(negedge clk); #1;
    rdDma = 1'b0;
    check("R13 status held", csrRdData, snap);

    // R10 correctable capture
    readOnce(w ^ 32'h20, mEnc(w), 20'h12345, 1'b0);
    check("R10 correctable log", csrRdData, {3'b001, 20'h12345, 2'b00, mCol(5)});

    // R8 + R12 uncorrectable capture with DMA
    syn2 = mCol(0) ^ mCol(1);
    readOnce(w ^ 32'h3, mEnc(w), 20'hABCDE, 1'b1);
    check("R8 R12 uncorr log", csrRdData, {3'b101, 20'hABCDE, 2'b10, syn2});

    // R9 repeat
    readOnce(w ^ 32'hC, mEnc(w), 20'h00001, 1'b0);
    check("R9 repeat", csrRdData, {3'b111, 20'hABCDE, 2'b10, syn2});

    // R10 correctable while uncorrectable logged
    readOnce(w ^ 32'h80, mEnc(w), 20'h00002, 1'b0);
    check("R10 held fields", csrRdData, {3'b111, 20'hABCDE, 2'b10, syn2});

    // R11 partial clear and read-only bits
    csrWrite(32'h8000_0000);
    check("R11 clear bit31", csrRdData, {3'b011, 20'hABCDE, 2'b10, syn2});
    csrWrite(32'h1FFF_FE7F);
    check("R11 read-only", csrRdData, {3'b011, 20'hABCDE, 2'b10, syn2});
    csrWrite(32'h6000_0100);
    check("R11 clear 30 29 8", csrRdData, {3'b000, 20'hABCDE, 2'b00, syn2});

    // R7 poisoned write
    @(negedge clk);
    wrEn = 1'b1; wrParErr = 1'b1; wrData = w; #1;
    c0 = wrCheck;
    check("R7 poisoned code", {25'h0, c0}, {25'h0, mEnc(w) ^ 7'b0000111});
    @(negedge clk);
    wrEn = 1'b0; wrParErr = 1'b0; #1;
    check("R7 parity flag", csrRdData, {3'b000, 20'hABCDE, 2'b01, syn2});
    @(negedge clk);
    rdValid = 1'b1; rdData = w; rdCheck = c0; rdPage = 20'h00077; #1;
    check("R7 readback uncorr", {29'h0, corrErr, chkErr, uncorrErr}, 32'h1);
    @(negedge clk);
    rdValid = 1'b0; #1;
    check("R7 poison logged", csrRdData, {3'b100, 20'h00077, 2'b01, 7'b0000111});

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule